// File: doc/BRIEF.md
# Software-Driven Flash Command Engine

This block runs one serial-flash transaction at a time on behalf of software. Software writes a control/status word with the execute bit set. The engine then walks through a fixed series of phases: an optional command byte, zero to four address bytes, up to 31 write bytes, a dummy phase, and up to 31 read bytes. Each phase length comes from a user configuration word. Every unit sent to the flash leaves through one outbound transfer stream. In the same cycle that a transfer is accepted, the flash side returns a byte on `rx_data`.

The configuration, command, address and write-data words are held outside the block. They arrive as plain inputs and must stay constant while a transaction runs. The block itself keeps three kinds of state: the control/status fields, the read-data words, and the chip-select state. A chip select can be held low by software across several transactions. It can also be asserted by the engine for the length of a single transaction. A sticky ready flag reports completion. That flag is cleared by writing 1 to it and can raise an interrupt.

The transfer stream follows valid/ready rules. Once `tx_valid` is high, it stays high and `tx_data`/`tx_nbits` stay unchanged until a cycle where `tx_ready` is also high. That cycle completes the transfer, and `rx_data` is taken in that same cycle. The flash side may hold `tx_ready` low for any number of cycles; the engine simply waits.

Top module: `flash_cmd_engine`

## Requirements
- R1: Writing the control/status word with bit 0 (execute) set while idle starts a transaction; bit 0 then reads 1 until completion. While busy, a write changes only the interrupt enable (bit 25) and may clear the ready flag; the chip-select mode (bit 16), device number (bits 9:8) and execute bit are left as they are.
- R2: Phases run in this order: command, address, write, dummy, read. The command phase sends `ucmd[7:0]` as one 8-bit transfer, and only when configuration bit 10 is 1.
- R3: Configuration bits 13:11 give the address byte count. Values 0 to 4 send that many bytes of `uaddr`, most significant first. Values 5 to 7 send no address bytes.
- R4: Configuration bits 20:16 give the write byte count. Write byte i uses byte lane i mod 4 (lane 0 = bits 7:0) of write word i/4. For i of 16 or more, the word is always word 3.
- R5: Configuration bits 23:21 give the dummy byte count. Dummy byte 0 takes bits 15:8 of `ucmd`, dummy byte 1 takes bits 23:16, and every later dummy byte takes bits 31:24.
- R6: Configuration bits 7:6 give a code c. Each dummy byte goes out as 8/2^c transfers of 2^c bits each, least significant bits first. `tx_nbits` = 2^c and the bits sit right-aligned in `tx_data`. All other transfers are 8 bits wide.
- R7: Configuration bits 28:24 give the read byte count. Read transfers send 0. Read byte i goes into lane i mod 4 of read word i/4. For i of 16 or more, the byte is clocked from the flash but not stored.
- R8: One cycle after the last accepted transfer, execute clears and the ready flag (bit 24) sets. A transaction with no phases completes in the same way, one cycle after it starts.
- R9: Writing 1 to bit 24 clears the ready flag and writing 0 leaves it as it is. If completion and a clearing write fall in the same cycle, the flag is set. `irq` = ready flag AND bit 25.
- R10: If bit 16 is 1 at start, the chip select chosen by the device number is low for the whole transaction and released at the end. If bit 16 is 0, the chip select stays as it was. At most one chip select is ever low.
- R11: While idle, changing bit 16 from 1 to 0 drives low the chip select of the device number held before the write. Changing it from 0 to 1 releases the active chip select, unless the new value also has execute set.
- R12: A device number of `CS_COUNT` or above selects no chip select. Every chip select is then released.
- R13: While `tx_valid` is high and `tx_ready` is low, the next cycle keeps `tx_valid` high with the same `tx_data` and `tx_nbits`.
- R14: After reset the control/status word reads 0x00010000, every chip select is released, the read words are zero and `tx_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cts_wr | input | 1 | Write strobe for the control/status word |
| cts_wdata | input | 32 | Control/status write value |
| cts_rdata | output | 32 | Current control/status word |
| irq | output | 1 | Ready interrupt |
| ucfg | input | 32 | User configuration word (phase sizes) |
| ucmd | input | 32 | Command byte and dummy bytes |
| uaddr | input | 32 | Flash address |
| wr_words | input | 128 | Four write-data words, word 0 in bits 31:0 |
| rd_words | output | 128 | Four read-data words, word 0 in bits 31:0 |
| tx_valid | output | 1 | Transfer offered |
| tx_ready | input | 1 | Transfer accepted |
| tx_data | output | 8 | Transfer payload, right-aligned |
| tx_nbits | output | 4 | Bits in this transfer (1, 2, 4 or 8) |
| rx_data | input | 8 | Byte returned by the flash in the accepting cycle |
| cs_n | output | CS_COUNT | Active-low chip selects |

## Verification
A reference model in the bench predicts every transfer from the register values and compares the stream against the design on every cycle. Different configurations separate the phase-skipping cases: a command plus address plus short read; a full five-phase run under random back-pressure; a run past 16 bytes with an invalid address size; each dummy width code; and a run with no phases at all. The back-pressure pattern shows whether the payload holds steady while stalled. The overflow run shows whether the lane mapping folds onto the last word and whether late read bytes are dropped. The chip-select sequences distinguish the held, per-transaction and out-of-range device cases, and writes issued mid-transaction show that busy writes are ignored.

// File: rtl/ufe_pkg.sv
package ufe_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_CMD  = 3'd1,
    PH_ADDR = 3'd2,
    PH_WR   = 3'd3,
    PH_DUM  = 3'd4,
    PH_RD   = 3'd5,
    PH_END  = 3'd6
  } phase_e;

  typedef struct packed {
    logic       cmd_en;
    logic [2:0] addr_n;
    logic [4:0] wr_n;
    logic [2:0] dum_n;
    logic [1:0] dum_code;
    logic [4:0] rd_n;
  } ucfg_t;

  typedef struct packed {
    logic       ie;
    logic       rdy;
    logic       swcs;
    logic [1:0] dev;
    logic       exec;
  } cts_t;

  function automatic ucfg_t decode_ucfg(logic [31:0] w);
    ucfg_t c;
    c.rd_n     = w[28:24];
    c.dum_n    = w[23:21];
    c.wr_n     = w[20:16];
    c.addr_n   = (w[13:11] > 3'd4) ? 3'd0 : w[13:11];
    c.cmd_en   = w[10];
    c.dum_code = w[7:6];
    return c;
  endfunction

  function automatic cts_t decode_cts(logic [31:0] w);
    cts_t s;
    s.ie   = w[25];
    s.rdy  = w[24];
    s.swcs = w[16];
    s.dev  = w[9:8];
    s.exec = w[0];
    return s;
  endfunction

endpackage

// File: rtl/ufe_seq.sv
module ufe_seq
  import ufe_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  ucfg_t        cfg,
  input  logic         tx_ready,
  output phase_e       phase,
  output logic [4:0]   idx,
  output logic [2:0]   sub,
  output logic         tx_valid,
  output logic         fire,
  output logic         finish
);

  function automatic logic [4:0] count_of(phase_e p, ucfg_t c);
    case (p)
      PH_CMD:  return {4'd0, c.cmd_en};
      PH_ADDR: return {2'd0, c.addr_n};
      PH_WR:   return c.wr_n;
      PH_DUM:  return {2'd0, c.dum_n};
      PH_RD:   return c.rd_n;
      default: return 5'd0;
    endcase
  endfunction

  // lowest non-empty phase at or after p, else the end state
  function automatic phase_e first_from(logic [2:0] p, ucfg_t c);
    phase_e r;
    r = PH_END;
    for (int k = 5; k >= 1; k--) begin
      if (k >= int'(p) && count_of(phase_e'(3'(k)), c) != 5'd0)
        r = phase_e'(3'(k));
    end
    return r;
  endfunction

  logic [4:0] cur_n;
  logic       last_sub;
  logic       last_idx;

  assign cur_n    = count_of(phase, cfg);
  assign tx_valid = (phase != PH_IDLE) && (phase != PH_END);
  assign fire     = tx_valid && tx_ready;
  assign finish   = (phase == PH_END);
  assign last_sub = (phase != PH_DUM) || (sub == 3'(32'd7 >> cfg.dum_code));
  assign last_idx = (idx == cur_n - 5'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      idx   <= '0;
      sub   <= '0;
    end else if (start) begin
      phase <= first_from(3'(PH_CMD), cfg);
      idx   <= '0;
      sub   <= '0;
    end else if (fire) begin
      if (!last_sub) begin
        sub <= sub + 3'd1;
      end else begin
        sub <= '0;
        if (last_idx) begin
          idx   <= '0;
          phase <= first_from(3'(phase) + 3'd1, cfg);
        end else begin
          idx <= idx + 5'd1;
        end
      end
    end else if (phase == PH_END) begin
      phase <= PH_IDLE;
    end
  end

  // R8: the end state lasts exactly one cycle
  assert_end_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_END) |=> (phase == PH_IDLE));

  // R1: the control side never starts a run while one is in flight
  assert_start_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (phase == PH_IDLE));

endmodule

// File: rtl/ufe_txmux.sv
module ufe_txmux
  import ufe_pkg::*;
(
  input  phase_e       phase,
  input  logic [4:0]   idx,
  input  logic [2:0]   sub,
  input  logic [2:0]   addr_n,
  input  logic [1:0]   dum_code,
  input  logic [31:0]  ucmd,
  input  logic [31:0]  uaddr,
  input  logic [127:0] wr_words,
  output logic [7:0]   tx_data,
  output logic [3:0]   tx_nbits
);

  logic [1:0] addr_sel;
  logic [1:0] wr_word;
  logic [1:0] dum_sel;
  logic [7:0] dum_byte;
  logic [3:0] dum_w;
  logic [2:0] dum_sh;
  logic [7:0] dum_mask;

  assign addr_sel = 2'(addr_n - 3'd1 - idx[2:0]);
  assign wr_word  = idx[4] ? 2'd3 : idx[3:2];
  assign dum_sel  = (idx == 5'd0) ? 2'd1 : (idx == 5'd1) ? 2'd2 : 2'd3;
  assign dum_byte = ucmd[{dum_sel, 3'b000} +: 8];
  assign dum_w    = 4'd1 << dum_code;
  assign dum_sh   = 3'({1'b0, sub} * dum_w);
  assign dum_mask = 8'((9'd1 << dum_w) - 9'd1);

  always_comb begin
    tx_data  = 8'd0;
    tx_nbits = 4'd8;
    case (phase)
      PH_CMD:  tx_data = ucmd[7:0];
      PH_ADDR: tx_data = uaddr[{addr_sel, 3'b000} +: 8];
      PH_WR:   tx_data = wr_words[{wr_word, idx[1:0], 3'b000} +: 8];
      PH_DUM: begin
        tx_data  = (dum_byte >> dum_sh) & dum_mask;
        tx_nbits = dum_w;
      end
      PH_RD:   tx_data = 8'd0;
      default: tx_nbits = 4'd0;
    endcase
  end

endmodule

// File: rtl/ufe_rdcap.sv
module ufe_rdcap #(
  parameter int NUM_WORDS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   capture,
  input  logic [4:0]             idx,
  input  logic [7:0]             rx_data,
  output logic [NUM_WORDS*32-1:0] rd_words
);

  localparam int BYTES = NUM_WORDS * 4;

  logic [7:0] bytes_q [BYTES];

  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        bytes_q[b] <= 8'd0;
      else if (capture && idx == 5'(b))
        bytes_q[b] <= rx_data;
    end
    assign rd_words[b*8 +: 8] = bytes_q[b];
  end

  // R7: stored read data moves only on a captured read transfer
  assert_rd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(rd_words));

endmodule

// File: rtl/ufe_ctl.sv
module ufe_ctl
  import ufe_pkg::*;
#(
  parameter int CS_COUNT = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cts_wr,
  input  logic [31:0]         cts_wdata,
  input  logic                finish,
  output logic                start,
  output logic                busy,
  output logic                irq,
  output logic [31:0]         cts_rdata,
  output logic [CS_COUNT-1:0] cs_n
);

  cts_t       w;
  logic       exec_q, rdy_q, ie_q, swcs_q;
  logic [1:0] dev_q;
  logic       act_v;
  logic [1:0] act_idx;

  assign w     = decode_cts(cts_wdata);
  assign start = cts_wr && !exec_q && w.exec;
  assign busy  = exec_q;
  assign irq   = rdy_q && ie_q;
  assign cts_rdata = {6'd0, ie_q, rdy_q, 7'd0, swcs_q, 6'd0, dev_q, 7'd0, exec_q};

  function automatic logic dev_ok(logic [1:0] d);
    return int'(d) < CS_COUNT;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exec_q  <= 1'b0;
      rdy_q   <= 1'b0;
      ie_q    <= 1'b0;
      swcs_q  <= 1'b1;
      dev_q   <= 2'd0;
      act_v   <= 1'b0;
      act_idx <= 2'd0;
    end else begin
      if (cts_wr) ie_q <= w.ie;
      if (finish) rdy_q <= 1'b1;
      else if (cts_wr && w.rdy) rdy_q <= 1'b0;

      if (finish) begin
        exec_q <= 1'b0;
        if (swcs_q) act_v <= 1'b0;
      end else if (cts_wr && !exec_q) begin
        swcs_q <= w.swcs;
        dev_q  <= w.dev;
        if (w.exec) exec_q <= 1'b1;
        if (w.exec && w.swcs) begin
          act_v   <= dev_ok(w.dev);
          act_idx <= w.dev;
        end else if (swcs_q && !w.swcs) begin
          act_v   <= dev_ok(dev_q);
          act_idx <= dev_q;
        end else if (!swcs_q && w.swcs) begin
          act_v <= 1'b0;
        end
      end
    end
  end

  for (genvar i = 0; i < CS_COUNT; i++) begin : g_cs
    assign cs_n[i] = !(act_v && act_idx == 2'(i));
  end

  // R10: never more than one device selected
  assert_cs_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  // R10: chip selects do not move in the middle of a transaction
  assert_cs_steady_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_q && !finish) |=> $stable(cs_n));

  // R8: execute only drops on completion
  assert_exec_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(exec_q) |-> $past(finish));

  // R9: completion wins over a clearing write
  assert_finish_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> rdy_q);

  // R12: an active select always names an existing device
  assert_dev_range_R12: assert property (@(posedge clk) disable iff (!rst_n)
    act_v |-> (int'(act_idx) < CS_COUNT));

endmodule

// File: rtl/flash_cmd_engine.sv
module flash_cmd_engine
  import ufe_pkg::*;
#(
  parameter int CS_COUNT  = 2,
  parameter int NUM_WORDS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cts_wr,
  input  logic [31:0]            cts_wdata,
  output logic [31:0]            cts_rdata,
  output logic                   irq,
  input  logic [31:0]            ucfg,
  input  logic [31:0]            ucmd,
  input  logic [31:0]            uaddr,
  input  logic [NUM_WORDS*32-1:0] wr_words,
  output logic [NUM_WORDS*32-1:0] rd_words,
  output logic                   tx_valid,
  input  logic                   tx_ready,
  output logic [7:0]             tx_data,
  output logic [3:0]             tx_nbits,
  input  logic [7:0]             rx_data,
  output logic [CS_COUNT-1:0]    cs_n
);

  ucfg_t      cfg;
  phase_e     phase;
  logic [4:0] idx;
  logic [2:0] sub;
  logic       start, busy, fire, finish;

  assign cfg = decode_ucfg(ucfg);

  ufe_ctl #(.CS_COUNT(CS_COUNT)) u_ctl (
    .clk(clk), .rst_n(rst_n), .cts_wr(cts_wr), .cts_wdata(cts_wdata),
    .finish(finish), .start(start), .busy(busy), .irq(irq),
    .cts_rdata(cts_rdata), .cs_n(cs_n)
  );

  ufe_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg(cfg), .tx_ready(tx_ready),
    .phase(phase), .idx(idx), .sub(sub), .tx_valid(tx_valid),
    .fire(fire), .finish(finish)
  );

  ufe_txmux u_mux (
    .phase(phase), .idx(idx), .sub(sub), .addr_n(cfg.addr_n),
    .dum_code(cfg.dum_code), .ucmd(ucmd), .uaddr(uaddr),
    .wr_words(wr_words[127:0]), .tx_data(tx_data), .tx_nbits(tx_nbits)
  );

  ufe_rdcap #(.NUM_WORDS(NUM_WORDS)) u_rd (
    .clk(clk), .rst_n(rst_n), .capture(fire && phase == PH_RD),
    .idx(idx), .rx_data(rx_data), .rd_words(rd_words)
  );

  // R13: a stalled offer holds its payload
  assert_tx_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_nbits)));

  // R1: transfers are only offered while execute reads 1
  assert_tx_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (busy && cts_rdata[0]));

endmodule

// File: tb/test_flash_cmd_engine.sv
module test_flash_cmd_engine;

  localparam int CS = 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cts_wr = 1'b0;
  logic [31:0]  cts_wdata = '0;
  logic [31:0]  cts_rdata;
  logic         irq;
  logic [31:0]  ucfg = '0, ucmd = '0, uaddr = '0;
  logic [127:0] wr_words = '0;
  logic [127:0] rd_words;
  logic         tx_valid, tx_ready = 1'b1;
  logic [7:0]   tx_data, rx_data = 8'h00;
  logic [3:0]   tx_nbits;
  logic [CS-1:0] cs_n;

  flash_cmd_engine #(.CS_COUNT(CS)) i_flash_cmd_engine (
    .clk(clk), .rst_n(rst_n), .cts_wr(cts_wr), .cts_wdata(cts_wdata),
    .cts_rdata(cts_rdata), .irq(irq), .ucfg(ucfg), .ucmd(ucmd), .uaddr(uaddr),
    .wr_words(wr_words), .rd_words(rd_words), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_nbits(tx_nbits),
    .rx_data(rx_data), .cs_n(cs_n)
  );

  always #10 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;

  function automatic string tag_name(int t);
    case (t)
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  typedef struct { logic [7:0] d; int nb; int rd; int tag; } xfer_t;
  xfer_t q[$];
  logic m_exec, m_rdy, m_ie, m_swcs;
  logic [1:0] m_dev;
  int   m_act;
  logic [7:0] m_rd [16];

  task automatic push(logic [7:0] d, int nb, int rd, int tag);
    xfer_t e;
    e.d = d; e.nb = nb; e.rd = rd; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic build_queue();
    int rdn, dn, wn, an, code, bpc;
    logic [7:0] b;
    rdn = int'(ucfg[28:24]); dn = int'(ucfg[23:21]); wn = int'(ucfg[20:16]);
    an = int'(ucfg[13:11]); code = int'(ucfg[7:6]); bpc = 1 << code;
    if (ucfg[10]) push(ucmd[7:0], 8, -1, 2);
    if (an <= 4) for (int j = an - 1; j >= 0; j--) push(uaddr[j*8 +: 8], 8, -1, 3);
    for (int i = 0; i < wn; i++) begin
      int wsel;
      wsel = (i < 16) ? i / 4 : 3;
      push(wr_words[wsel*32 + (i % 4)*8 +: 8], 8, -1, 4);
    end
    for (int k = 0; k < dn; k++) begin
      b = ucmd[((k < 2) ? k + 1 : 3)*8 +: 8];
      for (int t = 0; t < 8; t += bpc)
        push(8'((b >> t) & ((1 << bpc) - 1)), bpc, -1, (k >= 2) ? 5 : 6);
    end
    for (int i = 0; i < rdn; i++) push(8'h00, 8, i, 7);
  endtask

  function automatic int pick(logic [1:0] d);
    return (int'(d) < CS) ? int'(d) : -1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_exec = 0; m_rdy = 0; m_ie = 0; m_swcs = 1; m_dev = 0; m_act = -1;
      for (int i = 0; i < 16; i++) m_rd[i] = 8'h00;
      q.delete();
    end else begin
      logic old_exec, hs, fin;
      old_exec = m_exec;
      hs  = m_exec && q.size() > 0 && tx_ready;
      fin = m_exec && q.size() == 0;
      if (hs) begin
        xfer_t e;
        e = q.pop_front();
        if (e.rd >= 0 && e.rd < 16) m_rd[e.rd] = rx_data;
      end
      if (cts_wr) begin
        m_ie = cts_wdata[25];
        if (cts_wdata[24]) m_rdy = 0;
        if (!old_exec) begin
          if (cts_wdata[0] && cts_wdata[16]) m_act = pick(cts_wdata[9:8]);
          else if (m_swcs && !cts_wdata[16]) m_act = pick(m_dev);
          else if (!m_swcs && cts_wdata[16]) m_act = -1;
          m_swcs = cts_wdata[16];
          m_dev  = cts_wdata[9:8];
          if (cts_wdata[0]) begin
            m_exec = 1;
            build_queue();
          end
        end
      end
      if (fin) begin
        m_exec = 0;
        m_rdy  = 1;
        if (m_swcs) m_act = -1;
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      logic exp_v;
      logic [CS-1:0] exp_cs;
      logic [127:0] exp_rd;
      exp_v = m_exec && q.size() > 0;
      chk(exp_v ? tag_name(q[0].tag) : "R8", 128'(tx_valid), 128'(exp_v));
      if (exp_v) begin
        chk(tag_name(q[0].tag), 128'(tx_data), 128'(q[0].d));
        chk("R6", 128'(tx_nbits), 128'(q[0].nb));
      end
      chk("R1", 128'(cts_rdata[0]), 128'(m_exec));
      chk("R9", 128'(cts_rdata[24]), 128'(m_rdy));
      chk("R9", 128'(irq), 128'(m_rdy & m_ie));
      chk("R11", 128'({cts_rdata[25], cts_rdata[16], cts_rdata[9:8]}),
          128'({m_ie, m_swcs, m_dev}));
      for (int i = 0; i < CS; i++) exp_cs[i] = !(m_act == i);
      chk(m_act < 0 ? "R12" : "R10", 128'(cs_n), 128'(exp_cs));
      for (int i = 0; i < 16; i++) exp_rd[i*8 +: 8] = m_rd[i];
      chk("R7", rd_words, exp_rd);
    end
  end

  // flash-side responder: back-pressure and returned bytes
  logic [15:0] lfsr = 16'hACE1;
  bit ready_rand = 0;
  always @(posedge clk) begin
    #2;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    tx_ready = ready_rand ? lfsr[0] : 1'b1;
    rx_data  = lfsr[15:8];
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic cts_write(logic [31:0] v);
    @(posedge clk); #2;
    cts_wr = 1'b1; cts_wdata = v;
    @(posedge clk); #2;
    cts_wr = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (m_exec) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R14: reset state
    chk("R14", 128'(cts_rdata), 128'(32'h0001_0000));
    chk("R14", 128'(cs_n), 128'({CS{1'b1}}));
    chk("R14", 128'(tx_valid), 128'(0));
    chk("R14", rd_words, 128'(0));

    // R2 R3: command + 3 address bytes + 2 reads, per-transaction select of device 0
    ucfg = (32'd2 << 24) | (32'd3 << 11) | (32'd1 << 10);
    ucmd = 32'h0000_0003; uaddr = 32'h0012_3456;
    cts_write(32'h0001_0001);
    wait_idle();

    // R4 R5 R6: all five phases under back-pressure, interrupt enabled
    ready_rand = 1;
    ucfg = (32'd4 << 24) | (32'd2 << 21) | (32'd5 << 16) | (32'd4 << 11) | (32'd1 << 10);
    ucmd = 32'hC3A5_5A9F; uaddr = 32'h89AB_CDEF;
    wr_words = 128'h3333_3333_2222_2222_1111_1111_8877_6655;
    cts_write(32'h0201_0001);
    wait_idle();
    cts_write(32'h0201_0000); // R9: writing 0 keeps the flag
    cts_write(32'h0301_0000); // R9: writing 1 clears it

    // R4 R7 R3: overflow past 16 bytes, address size 6 sends nothing, device 1
    ucfg = (32'd20 << 24) | (32'd3 << 21) | (32'd20 << 16) | (32'd6 << 11) | (32'd2 << 6);
    wr_words = 128'hF0E1_D2C3_B4A5_9687_7869_5A4B_3C2D_1E0F;
    cts_write(32'h0001_0101);
    wait_idle();

    // R6: one-bit and eight-bit dummy widths
    ucfg = (32'd1 << 21) | (32'd1 << 6) | (32'd1 << 24);
    cts_write(32'h0001_0001);
    wait_idle();
    ucfg = (32'd4 << 21) | (32'd3 << 6);
    cts_write(32'h0001_0001);
    wait_idle();
    ucfg = (32'd2 << 21);
    cts_write(32'h0001_0001);
    wait_idle();

    // R8: empty transaction
    ucfg = 32'h0;
    cts_write(32'h0001_0001);
    wait_idle();

    // R11 R10: held select across commands
    ready_rand = 0;
    cts_write(32'h0001_0100);
    cts_write(32'h0000_0100);
    ucfg = (32'd1 << 10) | (32'd1 << 11);
    cts_write(32'h0000_0101);
    wait_idle();
    cts_write(32'h0001_0101);
    wait_idle();
    cts_write(32'h0000_0100);
    cts_write(32'h0001_0100);

    // R1: writes during a long run change only enable and ready flag
    ready_rand = 1;
    ucfg = (32'd31 << 24) | (32'd1 << 10);
    cts_write(32'h0001_0001);
    cts_write(32'h0200_0300);
    cts_write(32'h0100_0001);
    wait_idle();

    // R12: out-of-range device number
    cts_write(32'h0001_0300);
    ucfg = (32'd2 << 24);
    cts_write(32'h0001_0301);
    wait_idle();
    cts_write(32'h0000_0300);
    repeat (3) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule